// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Controller

This block stands between a group of interrupt sources and a single processor and decides what that processor is shown. It keeps a 32-bit presentation word. The top byte is the processor's current priority. The low 24 bits are the number of the source that is pending. It also keeps the priority of the pending source and a request priority for an inter-processor interrupt (IPI). It drives one interrupt line. Priority is numeric and lower is more urgent. The value 0xFF means "least urgent" or "none". A source number of zero means nothing is pending.

Sources offer interrupts with a number, a priority and an owner id. A better offer pushes out the source that is currently pending, and the pushed-out source receives a reject so that it can try again. When the processor raises its current priority, an interrupt that is already pending can be withdrawn. The processor reaches the block through one operation port. The operations are offer, set current priority, set IPI priority, accept, poll and end-of-interrupt. Requests back to the sources (reject, resend-all and end-of-interrupt) leave on one strobe channel, at most one per clock.

Top module: `irq_presenter`

## Requirements
- R1: After reset the presentation word is 0, the pending priority and the IPI priority are 0xFF, `irq_o` is low, no strobe is issued and `op_ready` is high.
- R2: An offer is rejected when its priority is not strictly below the current priority. A reject strobe (`req_kind`=1) then carries the offered number and owner, and the state is unchanged. `op_kind` codes are 0 offer, 1 set-current, 2 set-IPI, 3 accept, 4 poll and 5 end-of-interrupt. The priority of every operation sits in `op_data[31:24]` and the source number sits in `op_data[23:0]`.
- R3: An offer is also rejected when a source is pending whose priority is equal to or lower in number than the offered priority.
- R4: A taken offer latches the number, the priority and the owner, and raises `irq_o`. If a source owned by an owner was pending, that source gets a reject strobe carrying its number and its owner. `irq_o` is high exactly while the source field is non-zero.
- R5: Accept returns the word as it was before the accept. After the accept, the current priority takes the value of the pending priority, the source field is 0, the pending priority is 0xFF and `irq_o` is low.
- R6: Set-IPI stores the value. If the value is below the current priority, the IPI check runs. The check leaves the state alone when the pending priority is at or below the new value. Otherwise it rejects an owned pending source, loads source number `IPI_SRC` (default 2) at the IPI priority, raises `irq_o`, and records no owner.
- R7: Set-current with a lower value withdraws a pending source whose priority is not below the new value. The withdrawal clears the field, sets the pending priority to 0xFF and lowers `irq_o`. The owner, if there is one, gets a reject.
- R8: Set-current with an equal or higher value while nothing is pending runs the IPI check against the new value and issues one resend strobe (`req_kind`=2, number 0).
- R9: End-of-interrupt copies `op_data[31:24]` into the current priority and issues an EOI strobe (`req_kind`=3) with `op_data[23:0]`. If nothing is pending, it then runs the IPI check and a resend strobe follows in the next cycle.
- R10: Only the EOI-then-resend case drops `op_ready`, and only for one cycle. Every other operation leaves it high. Strobes appear one cycle after the operation is taken.
- R11: Poll returns the presentation word in `rd_word` and the IPI priority in `rd_ipi` and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Operation can be taken this cycle |
| op_kind | input | 3 | Operation code |
| op_data | input | 32 | Priority in [31:24], source number in [23:0] |
| op_owner | input | 4 | Owner id of an offering source |
| rd_valid | output | 1 | Read result valid (accept, poll) |
| rd_word | output | 32 | Presentation word before the operation |
| rd_ipi | output | 8 | IPI priority before the operation |
| irq_o | output | 1 | Interrupt line to the processor |
| req_valid | output | 1 | Strobe to sources |
| req_kind | output | 2 | 1 reject, 2 resend, 3 EOI |
| req_src | output | 24 | Source number of the strobe |
| req_owner | output | 4 | Owner addressed by a reject |

## Verification
The hardest state to reach is an end-of-interrupt with nothing pending while the IPI priority beats the newly restored current priority. In that case the IPI must be loaded in the same operation that produces two strobes in back-to-back cycles. The stimulus gets there in steps. It first lets an IPI displace an owned source, then accepts the IPI so that the source field empties with a low current priority, and then writes the end-of-interrupt with priority 0xFF. Withdrawal of an IPI without an owner, which must produce no strobe, is reached by a current-priority write exactly equal to the IPI priority.

// File: rtl/irq_presenter_pkg.sv
package irq_presenter_pkg;

    typedef enum logic [2:0] {
        OP_OFFER    = 3'd0,
        OP_SET_CUR  = 3'd1,
        OP_SET_IPI  = 3'd2,
        OP_ACCEPT   = 3'd3,
        OP_POLL     = 3'd4,
        OP_EOI      = 3'd5
    } op_kind_e;

    typedef enum logic [1:0] {
        REQ_NONE   = 2'd0,
        REQ_REJECT = 2'd1,
        REQ_RESEND = 2'd2,
        REQ_EOI    = 2'd3
    } req_kind_e;

    typedef struct packed {
        logic take;      // offer is latched
        logic bounce;    // offer goes back to its own source
        logic evict;     // the owned pending source gets a reject
    } offer_verdict_t;

    typedef struct packed {
        logic load;      // IPI number is loaded
        logic evict;     // the owned pending source gets a reject
    } ipi_verdict_t;

    function automatic logic ends_read(op_kind_e k);
        return (k == OP_ACCEPT) || (k == OP_POLL);
    endfunction

endpackage

// File: rtl/ip_offer_judge.sv
module ip_offer_judge
    import irq_presenter_pkg::*;
#(
    parameter int PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] offer_prio,
    input  logic [PRIO_W-1:0] cur_prio,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic              pend_busy,
    input  logic              pend_owned,
    output offer_verdict_t    verdict
);

    logic not_above_cur;
    logic loses_to_pend;

    always_comb begin
        not_above_cur   = (offer_prio >= cur_prio);
        loses_to_pend   = pend_busy && (pend_prio <= offer_prio);
        verdict.bounce  = not_above_cur || loses_to_pend;
        verdict.take    = !verdict.bounce;
        verdict.evict   = verdict.take && pend_busy && pend_owned;
    end

endmodule

// File: rtl/ip_ipi_judge.sv
module ip_ipi_judge
    import irq_presenter_pkg::*;
#(
    parameter int PRIO_W = 8
) (
    input  logic              enable,
    input  logic [PRIO_W-1:0] ipi_prio,
    input  logic [PRIO_W-1:0] cur_prio,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic              pend_busy,
    input  logic              pend_owned,
    output ipi_verdict_t      verdict
);

    logic beats_cur;
    logic held_off;

    always_comb begin
        beats_cur     = (ipi_prio < cur_prio);
        held_off      = pend_busy && (pend_prio <= ipi_prio);
        verdict.load  = enable && beats_cur && !held_off;
        verdict.evict = verdict.load && pend_busy && pend_owned;
    end

endmodule

// File: rtl/ip_strobe_seq.sv
module ip_strobe_seq
    import irq_presenter_pkg::*;
#(
    parameter int SRC_W   = 24,
    parameter int OWNER_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  req_kind_e          in_kind,
    input  logic [SRC_W-1:0]   in_src,
    input  logic [OWNER_W-1:0] in_owner,
    input  logic               in_tail,
    output logic               out_valid,
    output req_kind_e          out_kind,
    output logic [SRC_W-1:0]   out_src,
    output logic [OWNER_W-1:0] out_owner,
    output logic               busy
);

    logic tail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_kind  <= REQ_NONE;
            out_src   <= '0;
            out_owner <= '0;
            tail_q    <= 1'b0;
        end else if (tail_q) begin
            out_valid <= 1'b1;
            out_kind  <= REQ_RESEND;
            out_src   <= '0;
            out_owner <= '0;
            tail_q    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_kind  <= in_valid ? in_kind  : REQ_NONE;
            out_src   <= in_valid ? in_src   : '0;
            out_owner <= in_valid ? in_owner : '0;
            tail_q    <= in_tail;
        end
    end

    assign busy = tail_q;

    // R10
    tail_resend_chk: assert property (@(posedge clk) disable iff (rst)
        tail_q |=> (out_valid && out_kind == REQ_RESEND && !tail_q));

    // R10
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        tail_q |-> !in_valid);

endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
    import irq_presenter_pkg::*;
#(
    parameter int PRIO_W  = 8,
    parameter int SRC_W   = 24,
    parameter int OWNER_W = 4,
    parameter int IPI_SRC = 2,
    localparam int WORD_W = PRIO_W + SRC_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               op_valid,
    output logic               op_ready,
    input  logic [2:0]         op_kind,
    input  logic [WORD_W-1:0]  op_data,
    input  logic [OWNER_W-1:0] op_owner,
    output logic               rd_valid,
    output logic [WORD_W-1:0]  rd_word,
    output logic [PRIO_W-1:0]  rd_ipi,
    output logic               irq_o,
    output logic               req_valid,
    output logic [1:0]         req_kind,
    output logic [SRC_W-1:0]   req_src,
    output logic [OWNER_W-1:0] req_owner
);

    localparam logic [PRIO_W-1:0] PRIO_NONE = '1;
    localparam logic [SRC_W-1:0]  IPI_NUM   = SRC_W'(IPI_SRC);

    // presentation state
    logic [PRIO_W-1:0]  cur_q,   cur_d;
    logic [SRC_W-1:0]   src_q,   src_d;
    logic [PRIO_W-1:0]  pend_q,  pend_d;
    logic [PRIO_W-1:0]  ipi_q,   ipi_d;
    logic [OWNER_W-1:0] own_q,   own_d;
    logic               owned_q, owned_d;
    logic               irq_q,   irq_d;

    op_kind_e           kind;
    logic               fire;
    logic [PRIO_W-1:0]  op_prio;
    logic [SRC_W-1:0]   op_src;
    logic               busy_pend;
    logic               tail_busy;

    assign kind      = op_kind_e'(op_kind);
    assign fire      = op_valid && op_ready;
    assign op_prio   = op_data[WORD_W-1 -: PRIO_W];
    assign op_src    = op_data[SRC_W-1:0];
    assign busy_pend = (src_q != '0);
    assign op_ready  = !tail_busy;

    // offer decision
    offer_verdict_t ov;
    ip_offer_judge #(.PRIO_W(PRIO_W)) u_offer (
        .offer_prio (op_prio),
        .cur_prio   (cur_q),
        .pend_prio  (pend_q),
        .pend_busy  (busy_pend),
        .pend_owned (owned_q),
        .verdict    (ov)
    );

    // IPI check operand selection
    logic              ipi_en;
    logic [PRIO_W-1:0] ipi_sel;
    logic [PRIO_W-1:0] cur_sel;

    always_comb begin
        ipi_en  = 1'b0;
        ipi_sel = ipi_q;
        cur_sel = cur_q;
        if (fire) begin
            unique case (kind)
                OP_SET_IPI: begin
                    ipi_en  = 1'b1;
                    ipi_sel = op_prio;
                end
                OP_SET_CUR: begin
                    cur_sel = op_prio;
                    ipi_en  = !(op_prio < cur_q) && !busy_pend;
                end
                OP_EOI: begin
                    cur_sel = op_prio;
                    ipi_en  = !busy_pend;
                end
                default: ;
            endcase
        end
    end

    ipi_verdict_t iv;
    ip_ipi_judge #(.PRIO_W(PRIO_W)) u_ipi (
        .enable     (ipi_en),
        .ipi_prio   (ipi_sel),
        .cur_prio   (cur_sel),
        .pend_prio  (pend_q),
        .pend_busy  (busy_pend),
        .pend_owned (owned_q),
        .verdict    (iv)
    );

    // next state and first strobe
    logic               s_valid;
    req_kind_e          s_kind;
    logic [SRC_W-1:0]   s_src;
    logic [OWNER_W-1:0] s_owner;
    logic               s_tail;

    always_comb begin
        cur_d   = cur_q;
        src_d   = src_q;
        pend_d  = pend_q;
        ipi_d   = ipi_q;
        own_d   = own_q;
        owned_d = owned_q;
        irq_d   = irq_q;
        s_valid = 1'b0;
        s_kind  = REQ_NONE;
        s_src   = '0;
        s_owner = '0;
        s_tail  = 1'b0;
        if (fire) begin
            unique case (kind)
                OP_OFFER: begin
                    if (ov.bounce) begin
                        s_valid = 1'b1;
                        s_kind  = REQ_REJECT;
                        s_src   = op_src;
                        s_owner = op_owner;
                    end else begin
                        if (ov.evict) begin
                            s_valid = 1'b1;
                            s_kind  = REQ_REJECT;
                            s_src   = src_q;
                            s_owner = own_q;
                        end
                        src_d   = op_src;
                        pend_d  = op_prio;
                        own_d   = op_owner;
                        owned_d = 1'b1;
                        irq_d   = 1'b1;
                    end
                end
                OP_SET_CUR: begin
                    cur_d = op_prio;
                    if (op_prio < cur_q) begin
                        if (busy_pend && (op_prio <= pend_q)) begin
                            src_d   = '0;
                            pend_d  = PRIO_NONE;
                            irq_d   = 1'b0;
                            owned_d = 1'b0;
                            if (owned_q) begin
                                s_valid = 1'b1;
                                s_kind  = REQ_REJECT;
                                s_src   = src_q;
                                s_owner = own_q;
                            end
                        end
                    end else if (!busy_pend) begin
                        s_valid = 1'b1;
                        s_kind  = REQ_RESEND;
                    end
                end
                OP_SET_IPI: begin
                    ipi_d = op_prio;
                    if (iv.evict) begin
                        s_valid = 1'b1;
                        s_kind  = REQ_REJECT;
                        s_src   = src_q;
                        s_owner = own_q;
                    end
                end
                OP_ACCEPT: begin
                    cur_d   = pend_q;
                    src_d   = '0;
                    pend_d  = PRIO_NONE;
                    owned_d = 1'b0;
                    irq_d   = 1'b0;
                end
                OP_EOI: begin
                    cur_d   = op_prio;
                    s_valid = 1'b1;
                    s_kind  = REQ_EOI;
                    s_src   = op_src;
                    s_tail  = !busy_pend;
                end
                default: ;
            endcase
            if (iv.load) begin
                src_d   = IPI_NUM;
                pend_d  = ipi_sel;
                owned_d = 1'b0;
                irq_d   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q    <= '0;
            src_q    <= '0;
            pend_q   <= PRIO_NONE;
            ipi_q    <= PRIO_NONE;
            own_q    <= '0;
            owned_q  <= 1'b0;
            irq_q    <= 1'b0;
            rd_valid <= 1'b0;
            rd_word  <= '0;
            rd_ipi   <= PRIO_NONE;
        end else begin
            cur_q    <= cur_d;
            src_q    <= src_d;
            pend_q   <= pend_d;
            ipi_q    <= ipi_d;
            own_q    <= own_d;
            owned_q  <= owned_d;
            irq_q    <= irq_d;
            rd_valid <= fire && ends_read(kind);
            if (fire && ends_read(kind)) begin
                rd_word <= {cur_q, src_q};
                rd_ipi  <= ipi_q;
            end
        end
    end

    assign irq_o = irq_q;

    req_kind_e seq_kind;
    ip_strobe_seq #(.SRC_W(SRC_W), .OWNER_W(OWNER_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (s_valid),
        .in_kind   (s_kind),
        .in_src    (s_src),
        .in_owner  (s_owner),
        .in_tail   (s_tail),
        .out_valid (req_valid),
        .out_kind  (seq_kind),
        .out_src   (req_src),
        .out_owner (req_owner),
        .busy      (tail_busy)
    );
    assign req_kind = seq_kind;

    // R4
    irq_tracks_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o == (src_q != '0));

    // R5
    idle_pend_none_chk: assert property (@(posedge clk) disable iff (rst)
        (src_q == '0) |-> (pend_q == PRIO_NONE));

    // R5
    accept_lowers_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && kind == OP_ACCEPT) |=> (!irq_o && rd_valid && src_q == '0));

    // R10
    ready_dip_chk: assert property (@(posedge clk) disable iff (rst)
        !op_ready |=> op_ready);

    // R2
    reject_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == REQ_REJECT) |-> (req_src != '0));

    // R11
    poll_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && kind == OP_POLL) |=> ($stable(src_q) && $stable(cur_q) && $stable(ipi_q)));

endmodule

// File: tb/irq_presenter_test.sv
`timescale 1ns/1ps
module irq_presenter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic [2:0]  op_kind = '0;
    logic [31:0] op_data = '0;
    logic [3:0]  op_owner = '0;
    logic        rd_valid;
    logic [31:0] rd_word;
    logic [7:0]  rd_ipi;
    logic        irq_o;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [23:0] req_src;
    logic [3:0]  req_owner;

    always #2.5 clk = ~clk;

    irq_presenter uut (
        .clk(clk), .rst(rst),
        .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind),
        .op_data(op_data), .op_owner(op_owner),
        .rd_valid(rd_valid), .rd_word(rd_word), .rd_ipi(rd_ipi),
        .irq_o(irq_o),
        .req_valid(req_valid), .req_kind(req_kind), .req_src(req_src),
        .req_owner(req_owner)
    );

    localparam int K_OFFER = 0, K_CUR = 1, K_IPI = 2, K_ACC = 3, K_POLL = 4, K_EOI = 5;
    localparam int Q_REJ = 1, Q_RES = 2, Q_EOI = 3;

    typedef struct {
        int          kind;
        logic [23:0] src;
        logic [3:0]  owner;
        string       tag;
    } req_item_t;

    typedef struct {
        logic [31:0] word;
        logic [7:0]  ipi;
        string       tag;
    } rd_item_t;

    req_item_t req_q[$];
    rd_item_t  rd_q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic exp_req(input int k, input logic [23:0] s, input logic [3:0] o, input string tag);
        req_item_t it;
        it.kind = k; it.src = s; it.owner = o; it.tag = tag;
        req_q.push_back(it);
    endtask

    task automatic exp_rd(input logic [31:0] w, input logic [7:0] p, input string tag);
        rd_item_t it;
        it.word = w; it.ipi = p; it.tag = tag;
        rd_q.push_back(it);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input int k, input logic [31:0] d, input logic [3:0] o);
        @(negedge clk);
        while (!op_ready) @(negedge clk);
        op_valid = 1'b1;
        op_kind  = k[2:0];
        op_data  = d;
        op_owner = o;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic poll(input logic [31:0] w, input logic [7:0] p, input string tag);
        exp_rd(w, p, tag);
        do_op(K_POLL, 32'h0, 4'h0);
    endtask

    task automatic drain(input string tag);
        repeat (3) @(negedge clk);
        chk({tag, " strobes outstanding"}, req_q.size(), 0);
        chk({tag, " reads outstanding"}, rd_q.size(), 0);
    endtask

    // monitor: compares produced strobes and reads with the queues
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (req_valid) begin
                    checks++;
                    if (req_q.size() == 0) begin
                        fails++;
                        $display("FAIL R10 unexpected strobe actual kind=%0d src=%h expected none",
                                 req_kind, req_src);
                    end else begin
                        req_item_t e;
                        e = req_q.pop_front();
                        if (int'(req_kind) != e.kind || req_src !== e.src || req_owner !== e.owner) begin
                            fails++;
                            $display("FAIL %s strobe actual kind=%0d src=%h owner=%h expected kind=%0d src=%h owner=%h",
                                     e.tag, req_kind, req_src, req_owner, e.kind, e.src, e.owner);
                        end
                    end
                end
                if (rd_valid) begin
                    checks++;
                    if (rd_q.size() == 0) begin
                        fails++;
                        $display("FAIL R11 unexpected read actual=%h expected none", rd_word);
                    end else begin
                        rd_item_t r;
                        r = rd_q.pop_front();
                        if (rd_word !== r.word || rd_ipi !== r.ipi) begin
                            fails++;
                            $display("FAIL %s read actual=%h/%h expected=%h/%h",
                                     r.tag, rd_word, rd_ipi, r.word, r.ipi);
                        end
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", op_ready, 1);
        chk("R1 irq", irq_o, 0);
        chk("R1 no strobe", req_valid, 0);
        poll(32'h0000_0000, 8'hFF, "R1 R11 reset word");
        drain("R1");

        // R2 current priority 0 bounces everything
        exp_req(Q_REJ, 24'h10, 4'h1, "R2 bounce at cur 0");
        do_op(K_OFFER, 32'h05_000010, 4'h1);
        chk("R2 irq stays low", irq_o, 0);
        drain("R2");

        // R8 open current priority, nothing pending
        exp_req(Q_RES, 24'h0, 4'h0, "R8 resend");
        do_op(K_CUR, 32'hFF_000000, 4'h0);
        chk("R8 irq", irq_o, 0);
        drain("R8");

        // R4 taken offer
        do_op(K_OFFER, 32'h40_000020, 4'h3);
        chk("R4 irq raised", irq_o, 1);
        poll(32'hFF00_0020, 8'hFF, "R4 latched");
        drain("R4 take");

        // R3 equal priority to pending is bounced
        exp_req(Q_REJ, 24'h21, 4'h4, "R3 equal pending");
        do_op(K_OFFER, 32'h40_000021, 4'h4);
        drain("R3");

        // R4 displacement
        exp_req(Q_REJ, 24'h20, 4'h3, "R4 displaced");
        do_op(K_OFFER, 32'h30_000022, 4'h5);
        poll(32'hFF00_0022, 8'hFF, "R4 new pending");
        drain("R4 displace");

        // R2 boundary: priority equal to current
        exp_req(Q_REJ, 24'h23, 4'h6, "R2 equal cur");
        do_op(K_OFFER, 32'hFF_000023, 4'h6);
        drain("R2 boundary");

        // R6 IPI held off by equal pending priority
        do_op(K_IPI, 32'h30_000000, 4'h0);
        poll(32'hFF00_0022, 8'h30, "R6 held off");
        drain("R6 hold");

        // R6 IPI displaces owned source
        exp_req(Q_REJ, 24'h22, 4'h5, "R6 ipi evicts");
        do_op(K_IPI, 32'h10_000000, 4'h0);
        chk("R6 irq", irq_o, 1);
        poll(32'hFF00_0002, 8'h10, "R6 ipi loaded");
        drain("R6 load");

        // R5 accept
        exp_rd(32'hFF00_0002, 8'h10, "R5 accept word");
        do_op(K_ACC, 32'h0, 4'h0);
        chk("R5 irq lowered", irq_o, 0);
        poll(32'h1000_0000, 8'h10, "R5 after accept");
        drain("R5");

        // R9 EOI with nothing pending: EOI, then resend, IPI reloaded
        exp_req(Q_EOI, 24'h02, 4'h0, "R9 eoi strobe");
        exp_req(Q_RES, 24'h0, 4'h0, "R9 tail resend");
        do_op(K_EOI, 32'hFF_000002, 4'h0);
        chk("R10 ready dips", op_ready, 0);
        chk("R9 ipi reloaded irq", irq_o, 1);
        @(negedge clk);
        chk("R10 ready back", op_ready, 1);
        poll(32'hFF00_0002, 8'h10, "R9 word");
        drain("R9 tail");

        // R6 IPI not better than current: stored only
        do_op(K_IPI, 32'hFF_000000, 4'h0);
        poll(32'hFF00_0002, 8'hFF, "R6 store only");
        // R7 lower current, pending still better: kept
        do_op(K_CUR, 32'h80_000000, 4'h0);
        chk("R7 kept irq", irq_o, 1);
        poll(32'h8000_0002, 8'hFF, "R7 kept");
        // R7 withdraw unowned IPI: no strobe
        do_op(K_CUR, 32'h10_000000, 4'h0);
        chk("R7 withdrawn irq", irq_o, 0);
        poll(32'h1000_0000, 8'hFF, "R7 withdrawn");
        drain("R7 ipi");

        // R8 worse current, nothing pending
        exp_req(Q_RES, 24'h0, 4'h0, "R8 resend again");
        do_op(K_CUR, 32'h20_000000, 4'h0);
        drain("R8 again");

        // R7 withdraw owned source
        do_op(K_OFFER, 32'h08_000030, 4'h7);
        chk("R4 irq owned", irq_o, 1);
        exp_req(Q_REJ, 24'h30, 4'h7, "R7 owner reject");
        do_op(K_CUR, 32'h05_000000, 4'h0);
        chk("R7 irq low", irq_o, 0);
        poll(32'h0500_0000, 8'hFF, "R7 owned withdrawn");
        drain("R7 owned");

        // R9 EOI nothing pending, IPI idle
        exp_req(Q_EOI, 24'h30, 4'h0, "R9 eoi 30");
        exp_req(Q_RES, 24'h0, 4'h0, "R9 resend 30");
        do_op(K_EOI, 32'hFF_000030, 4'h0);
        chk("R10 ready dips 2", op_ready, 0);
        chk("R9 irq idle", irq_o, 0);
        drain("R9 second");

        // R9 R10 EOI while pending: no resend, ready stays high
        do_op(K_OFFER, 32'h50_000040, 4'h2);
        exp_req(Q_EOI, 24'h11, 4'h0, "R9 eoi pending");
        do_op(K_EOI, 32'h60_000011, 4'h0);
        chk("R10 ready stays", op_ready, 1);
        poll(32'h6000_0040, 8'hFF, "R9 cur restored");
        drain("R9 pending");

        // R6 IPI evicts owned pending under non-FF current
        exp_req(Q_REJ, 24'h40, 4'h2, "R6 evict 40");
        do_op(K_IPI, 32'h20_000000, 4'h0);
        chk("R6 irq high", irq_o, 1);
        poll(32'h6000_0002, 8'h20, "R6 ipi 2");
        drain("R6 second");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule